// File: doc/BRIEF.md
# Four-State Mealy Controller for an Accumulator Processor

This block sequences a small accumulator machine that uses an 8-bit instruction word. A two-bit state register moves through four levels, one clock cycle each: fetch, decode, a wait level that leaves time for the operand memory access, and execute. The strobes sent to the datapath are a Mealy function of the current level, the 3-bit opcode field of the instruction register, and, for the conditional jumps only, the accumulator flags that report zero and positive.

The datapath, memory, ALU and I/O devices sit outside the block. They act on the strobes at the next clock edge. Every instruction therefore costs four cycles, and the halt instruction parks the machine until a synchronous reset arrives. The execute level has no state of its own for each instruction: the opcode is decoded combinationally there.

Top module: `mealy_ctrl`

## Requirements
- R1: While `rst` is high every output is 0. In the first cycle after `rst` falls, the controller is in fetch.
- R2: In fetch, `irLoad`=1, `pcLoad`=1 and `jmpSel`=0 (incrementer selected), and every other output is 0, whatever the opcode and flags are.
- R3: The levels follow each other fetch, decode, wait, execute, one cycle each. In decode and in wait every output is 0.
- R4: In execute, opcodes 000 (load), 010 (add), 011 (subtract) and 100 (input) set `accLoad`=1. `accSrc` is 00 for memory (load), 01 for ALU (add, subtract) and 10 for the input port (input). In every other case `accSrc` is 00.
- R5: `memWrite` is 1 only in execute with opcode 001 (store).
- R6: `jmpSel` is 1 in execute exactly when the opcode is 101 (jump if zero) or 110 (jump if positive), whatever the flags are.
- R7: In execute, `pcLoad` is 1 for opcode 101 only with `accZero`=1, and for opcode 110 only with `accPos`=1. It is 0 for every other opcode and flag combination in execute. Outside the two jump opcodes the flags have no effect on any output.
- R8: Opcode 111 (halt) sets `halt`=1 in execute. The controller then stays in execute with `halt`=1 and all other outputs 0 until `rst` is asserted.
- R9: After execute of any opcode other than 111, the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 3 | Opcode field of the instruction register |
| accZero | input | 1 | Accumulator equals zero |
| accPos | input | 1 | Accumulator is greater than zero |
| irLoad | output | 1 | Load the instruction register from memory |
| pcLoad | output | 1 | Load the program counter |
| jmpSel | output | 1 | PC input mux: 1 takes the instruction address field, 0 takes the incrementer |
| accLoad | output | 1 | Load the accumulator |
| accSrc | output | 2 | Accumulator source: 00 memory, 01 ALU, 10 input port |
| memWrite | output | 1 | Write the accumulator to memory |
| halt | output | 1 | Machine halted |

## Verification
The properties assume that the opcode field holds steady from the fetch of an instruction through its execute level, because an instruction register reloads only in fetch. In particular, the halt property expects opcode 111 to stay on the input for as long as the machine is parked. The stimulus drives each instruction's opcode and flags for its full four cycles and changes them only when the next fetch begins. During a halt it keeps the opcode at 111 until reset is applied. The flags are varied freely for every opcode, including the non-jump ones, so that their lack of effect there shows at the outputs.

// File: rtl/mealy_ctrl_pkg.sv
package mealy_ctrl_pkg;
  localparam int OP_W  = 3;
  localparam int SRC_W = 2;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'b00,
    ST_DECODE = 2'b01,
    ST_WAIT   = 2'b10,
    ST_EXEC   = 2'b11
  } cpuState_t;

  typedef enum logic [SRC_W-1:0] {
    SRC_MEM = 2'b00,
    SRC_ALU = 2'b01,
    SRC_IN  = 2'b10
  } accSrc_t;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'b000;
  localparam logic [OP_W-1:0] OP_STORE = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD   = 3'b010;
  localparam logic [OP_W-1:0] OP_SUB   = 3'b011;
  localparam logic [OP_W-1:0] OP_IN    = 3'b100;
  localparam logic [OP_W-1:0] OP_JZ    = 3'b101;
  localparam logic [OP_W-1:0] OP_JPOS  = 3'b110;
  localparam logic [OP_W-1:0] OP_HALT  = 3'b111;

  typedef struct packed {
    logic    irLoad;
    logic    pcLoad;
    logic    jmpSel;
    logic    accLoad;
    accSrc_t accSrc;
    logic    memWrite;
    logic    halt;
  } strobes_t;
endpackage

// File: rtl/ctl_seq.sv
module ctl_seq
  import mealy_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output cpuState_t       curState
);
  cpuState_t nextState;

  always_comb begin
    unique case (curState)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: nextState = ST_WAIT;
      ST_WAIT:   nextState = ST_EXEC;
      ST_EXEC:   nextState = (opcode == OP_HALT) ? ST_EXEC : ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nextState;
  end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import mealy_ctrl_pkg::*;
(
  input  logic            rst,
  input  cpuState_t       curState,
  input  logic [OP_W-1:0] opcode,
  input  logic            accZero,
  input  logic            accPos,
  output strobes_t        strobes
);
  strobes_t execStrobes;

  always_comb begin
    execStrobes = '0;
    unique case (opcode)
      OP_LOAD:  begin execStrobes.accLoad = 1'b1; execStrobes.accSrc = SRC_MEM; end
      OP_STORE: execStrobes.memWrite = 1'b1;
      OP_ADD,
      OP_SUB:   begin execStrobes.accLoad = 1'b1; execStrobes.accSrc = SRC_ALU; end
      OP_IN:    begin execStrobes.accLoad = 1'b1; execStrobes.accSrc = SRC_IN; end
      OP_JZ:    begin execStrobes.jmpSel = 1'b1; execStrobes.pcLoad = accZero; end
      OP_JPOS:  begin execStrobes.jmpSel = 1'b1; execStrobes.pcLoad = accPos; end
      default:  execStrobes.halt = 1'b1;
    endcase
  end

  always_comb begin
    strobes = '0;
    if (!rst) begin
      unique case (curState)
        ST_FETCH: begin
          strobes.irLoad = 1'b1;
          strobes.pcLoad = 1'b1;
        end
        ST_EXEC: strobes = execStrobes;
        default: strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/mealy_ctrl.sv
module mealy_ctrl
  import mealy_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic             accZero,
  input  logic             accPos,
  output logic             irLoad,
  output logic             pcLoad,
  output logic             jmpSel,
  output logic             accLoad,
  output logic [SRC_W-1:0] accSrc,
  output logic             memWrite,
  output logic             halt
);
  cpuState_t curState;
  strobes_t  strobes;

  ctl_seq uSeq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .curState (curState)
  );

  ctl_decode uDecode (
    .rst      (rst),
    .curState (curState),
    .opcode   (opcode),
    .accZero  (accZero),
    .accPos   (accPos),
    .strobes  (strobes)
  );

  assign irLoad   = strobes.irLoad;
  assign pcLoad   = strobes.pcLoad;
  assign jmpSel   = strobes.jmpSel;
  assign accLoad  = strobes.accLoad;
  assign accSrc   = strobes.accSrc;
  assign memWrite = strobes.memWrite;
  assign halt     = strobes.halt;
endmodule

// File: rtl/mealy_ctrl_chk.sv
module mealy_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] opcode,
  input logic       accZero,
  input logic       accPos,
  input logic       irLoad,
  input logic       pcLoad,
  input logic       jmpSel,
  input logic       accLoad,
  input logic [1:0] accSrc,
  input logic       memWrite,
  input logic       halt
);
  // R1: quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> !(irLoad || pcLoad || jmpSel || accLoad || memWrite || halt) && accSrc == 2'b00);

  // R1: reset release lands in fetch
  a_r1_fetch_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> irLoad);

  // R3: fetch is followed by a silent decode level
  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> !(irLoad || pcLoad || jmpSel || accLoad || memWrite || halt));

  // R2: main strobes never overlap
  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irLoad, accLoad, memWrite, halt, jmpSel}));

  // R5: writes only for a store
  a_r5_write_only_store: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> opcode == 3'b001);

  // R6: jump select only for the two jump opcodes
  a_r6_jmp_only_branch: assert property (@(posedge clk) disable iff (rst)
    jmpSel |-> (opcode == 3'b101 || opcode == 3'b110));

  // R7: a jump loads the PC exactly when its flag is set
  a_r7_branch_gate: assert property (@(posedge clk) disable iff (rst)
    jmpSel |-> pcLoad == ((opcode == 3'b101 && accZero) || (opcode == 3'b110 && accPos)));

  // R8: halt is sticky until reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R9: after any non-halt execute strobe, fetch follows
  a_r9_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (accLoad || memWrite || jmpSel) |=> irLoad);
endmodule

bind mealy_ctrl mealy_ctrl_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .accZero  (accZero),
  .accPos   (accPos),
  .irLoad   (irLoad),
  .pcLoad   (pcLoad),
  .jmpSel   (jmpSel),
  .accLoad  (accLoad),
  .accSrc   (accSrc),
  .memWrite (memWrite),
  .halt     (halt)
);

// File: tb/mealy_ctrl_test.sv
module mealy_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opcode = 3'b000;
  logic       accZero = 1'b0;
  logic       accPos = 1'b0;
  logic       irLoad, pcLoad, jmpSel, accLoad, memWrite, halt;
  logic [1:0] accSrc;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Packed as {irLoad, pcLoad, jmpSel, accLoad, accSrc[1:0], memWrite, halt}
  typedef struct {
    logic [7:0] vec;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  mealy_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .accZero(accZero), .accPos(accPos),
    .irLoad(irLoad), .pcLoad(pcLoad), .jmpSel(jmpSel), .accLoad(accLoad),
    .accSrc(accSrc), .memWrite(memWrite), .halt(halt)
  );

  always #5 clk = ~clk;

  localparam logic [7:0] V_IDLE  = 8'b0000_0000;
  localparam logic [7:0] V_FETCH = 8'b1100_0000;
  localparam logic [7:0] V_HALT  = 8'b0000_0001;

  // Execute-level vector derived from the requirement text
  function automatic logic [7:0] execVec(input logic [2:0] op, input logic z, input logic p);
    case (op)
      3'b000:  return 8'b0001_0000;               // R4 load, source memory 00
      3'b001:  return 8'b0000_0010;               // R5 store
      3'b010,
      3'b011:  return 8'b0001_0100;               // R4 ALU source 01
      3'b100:  return 8'b0001_1000;               // R4 input source 10
      3'b101:  return {1'b0, z, 1'b1, 5'b0};      // R6 R7 jump if zero
      3'b110:  return {1'b0, p, 1'b1, 5'b0};      // R6 R7 jump if positive
      default: return V_HALT;                     // R8
    endcase
  endfunction

  task automatic driveCycle(input logic r, input logic [2:0] op, input logic z,
                            input logic p, input logic [7:0] vec, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = r; opcode = op; accZero = z; accPos = p;
    it.vec = vec; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic runInstr(input logic [2:0] op, input logic z, input logic p, input string tag);
    driveCycle(1'b0, op, z, p, V_FETCH, "R2");
    driveCycle(1'b0, op, z, p, V_IDLE, "R3");
    driveCycle(1'b0, op, z, p, V_IDLE, "R3");
    driveCycle(1'b0, op, z, p, execVec(op, z, p), tag);
  endtask

  // Monitor: compares one expected item per cycle, after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        act = {irLoad, pcLoad, jmpSel, accLoad, accSrc, memWrite, halt};
        total++;
        if (act !== it.vec) begin
          bad++;
          $display("FAIL %s: outputs actual=%b expected=%b (op=%b z=%b p=%b)",
                   it.tag, act, it.vec, opcode, accZero, accPos);
        end
      end
    end
  end

  initial begin
    // R1 reset holds every output at 0
    for (int i = 0; i < 3; i++) driveCycle(1'b1, 3'b101, 1'b1, 1'b1, V_IDLE, "R1");
    // R1 first cycle after reset is fetch; R2 R3 R4 R9 load
    runInstr(3'b000, 1'b0, 1'b0, "R4");
    runInstr(3'b001, 1'b1, 1'b1, "R5");
    runInstr(3'b010, 1'b0, 1'b1, "R4");
    runInstr(3'b011, 1'b1, 1'b0, "R4");
    runInstr(3'b100, 1'b1, 1'b1, "R4");
    // R7 flags have no effect outside the jumps
    runInstr(3'b000, 1'b1, 1'b1, "R7");
    runInstr(3'b001, 1'b0, 1'b0, "R7");
    // R6 R7 jump if zero, taken and not taken
    runInstr(3'b101, 1'b1, 1'b0, "R7");
    runInstr(3'b101, 1'b0, 1'b1, "R7");
    // R6 R7 jump if positive, taken and not taken
    runInstr(3'b110, 1'b0, 1'b1, "R7");
    runInstr(3'b110, 1'b1, 1'b0, "R6");
    runInstr(3'b110, 1'b1, 1'b1, "R6");
    // R9 back-to-back after a jump reaches fetch again
    runInstr(3'b010, 1'b0, 1'b0, "R9");
    // R8 halt then stay parked
    runInstr(3'b111, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 6; i++) driveCycle(1'b0, 3'b111, i[0], i[1], V_HALT, "R8");
    // R1 reset leaves the halt
    driveCycle(1'b1, 3'b111, 1'b0, 1'b0, V_IDLE, "R1");
    driveCycle(1'b1, 3'b111, 1'b0, 1'b0, V_IDLE, "R1");
    runInstr(3'b100, 1'b0, 1'b0, "R1");
    // R1 reset in the middle of an instruction
    driveCycle(1'b0, 3'b011, 1'b0, 1'b0, V_FETCH, "R2");
    driveCycle(1'b0, 3'b011, 1'b0, 1'b0, V_IDLE, "R3");
    driveCycle(1'b1, 3'b011, 1'b0, 1'b0, V_IDLE, "R1");
    runInstr(3'b011, 1'b0, 1'b0, "R9");
    runInstr(3'b101, 1'b1, 1'b1, "R9");
    @(negedge clk);
    #3;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule